// File: doc/BRIEF.md
# Daisy-Chainable SPI Slave Shifter

This block is a serial slave meant to sit in a chain of identical devices that all share one active-low select line. Each device's serial output feeds the serial input of the next, so that while select is low the chain behaves as one long shift register with one word-wide stage per device. Whatever a device has captured when select rises is handed to local logic on a parallel output, with a one-cycle valid strobe. During the next frame it is shifted out again, most-significant bit first. Local logic may instead load a parallel word while the bus is idle, and that word is then sent in place of the echo.

The serial clock, data input and select are brought into the system clock domain through two flip-flops each. Edges of the serial clock are then detected in that domain. The clock idle level and the sampling phase are static mode inputs, with mode number = 2*polarity + phase. The control is a three-state machine. IDLE waits with select high, preloads the output bit and accepts parallel loads. SHIFT runs while select is low, sampling and shifting on the edges chosen by the mode. DONE lasts one cycle after select rises and publishes the word. The transitions are IDLE->SHIFT on select low, SHIFT->DONE on select high, and DONE->IDLE unconditionally.

Top module: `spi_chain_slave`

## Requirements
- R1: After reset `rx_valid` is 0, `rx_word` is 0 and `spi_miso` is 0, which is also the first echo word.
- R2: The bits sampled on `spi_mosi` enter the least-significant end of the shift register, so the first bit of the last `WORD_W` bits ends up as the most-significant bit. When select rises, those last `WORD_W` bits appear on `rx_word`.
- R3: Each rising edge of `spi_cs_n` that ends a frame gives exactly one single-cycle pulse on `rx_valid`. `rx_word` changes only in that cycle.
- R4: In the frame that follows, `spi_miso` sends the word captured in the previous frame, most-significant bit first.
- R5: With `cpha`=0, the first output bit is present on `spi_miso` before the first serial clock edge. Input is sampled on the edge that leaves the idle level set by `cpol`, and the output changes on the edge that returns to it.
- R6: With `cpha`=1, the output changes on the edge that leaves the idle level, and input is sampled on the edge that returns to it. All four `{cpol,cpha}` combinations work.
- R7: In a frame of k*`WORD_W` clocks, `spi_miso` sends the previous echo word and then the first (k-1)*`WORD_W` received bits, delayed by `WORD_W` bits. `rx_word` holds the last `WORD_W` bits.
- R8: A `load_en` pulse while select is high replaces the next frame's outgoing word with `load_data`.
- R9: `load_en` asserted while select is low has no effect on the next frame's outgoing word.
- R10: Toggling `spi_sclk` and `spi_mosi` while select is high produces no `rx_valid` pulse and leaves the outgoing word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level (static) |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge (static) |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data in (from master or previous device) |
| spi_cs_n | input | 1 | Shared active-low select |
| spi_miso | output | 1 | Serial data out (to master or next device) |
| load_en | input | 1 | Replace the outgoing word with load_data (idle only) |
| load_data | input | WORD_W | Local word to send in the next frame |
| rx_word | output | WORD_W | Word captured in the last frame |
| rx_valid | output | 1 | One-cycle strobe when rx_word is updated |

## Verification
All 256 byte values are sent, split so that each of the four clock modes carries 64 of them. Each frame's output is compared with the previous frame's input, which separates a correct echo from a register that is off by a bit, reversed, or shifting on the wrong edge. Frames of 24 clocks in two modes show that the block behaves as an 8-bit delay stage and not as a word that stops after 8 bits. Parallel loads are tried both while idle and in the middle of a frame, and clock and data are toggled with select high. Together these separate accepted inputs from ignored ones.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } chain_state_t;
endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {STAGES{RST_VAL[i]}};
            else        pipe <= {pipe[STAGES-2:0], din[i]};
        end
        assign dout[i] = pipe[STAGES-1];
    end
endmodule

// File: rtl/spi_chain_edges.sv
module spi_chain_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic cpha,
    input  logic sclk_s,
    output logic sample_stb,
    output logic shift_stb
);
    logic prev_q;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sclk_s;
    end

    assign rise  = sclk_s & ~prev_q;
    assign fall  = ~sclk_s & prev_q;
    assign lead  = cpol ? fall : rise;
    assign trail = cpol ? rise : fall;

    assign sample_stb = cpha ? trail : lead;
    assign shift_stb  = cpha ? lead  : trail;
endmodule

// File: rtl/spi_chain_fsm.sv
module spi_chain_fsm
    import spi_chain_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic              sample_stb,
    input  logic              shift_stb,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    output logic              miso,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output chain_state_t      state_o
);
    localparam int MSB = WORD_W - 1;

    chain_state_t state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic              miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_s) state_d = ST_SHIFT;
            ST_SHIFT: if (cs_s)  state_d = ST_DONE;
            ST_DONE:             state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            miso_q   <= 1'b0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (load_en) shreg_q <= load_data;
                    miso_q <= shreg_q[MSB];
                end
                ST_SHIFT: begin
                    if (sample_stb) shreg_q <= {shreg_q[MSB-1:0], mosi_s};
                    if (shift_stb)  miso_q  <= shreg_q[MSB];
                end
                ST_DONE: begin
                    rx_word  <= shreg_q;
                    rx_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign miso    = miso_q;
    assign state_o = state_q;
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in, sync_out;
    logic cs_s, sclk_s, mosi_s;
    logic sample_stb, shift_stb;
    chain_state_t fsm_state;

    assign raw_in = {spi_cs_n, spi_sclk, spi_mosi};
    assign {cs_s, sclk_s, mosi_s} = sync_out;

    spi_chain_sync #(
        .N(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
    ) sync_i (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_out)
    );

    spi_chain_edges edges_i (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
        .sclk_s(sclk_s), .sample_stb(sample_stb), .shift_stb(shift_stb)
    );

    spi_chain_fsm #(.WORD_W(WORD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .mosi_s(mosi_s),
        .sample_stb(sample_stb), .shift_stb(shift_stb),
        .load_en(load_en), .load_data(load_data),
        .miso(spi_miso), .rx_word(rx_word), .rx_valid(rx_valid),
        .state_o(fsm_state)
    );
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk
    import spi_chain_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              load_en,
    input logic              spi_miso,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid,
    input chain_state_t      state
);
    // R3: strobe lasts a single cycle
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: the received word moves only together with the strobe
    a_r3_word_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));

    // R10: a strobe is only seen with select deasserted
    a_r10_valid_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> spi_cs_n);

    // R10: while idle and with no load, serial clock activity cannot move the output
    a_r10_idle_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE && $past(state, 2) == ST_IDLE
         && !$past(load_en) && !$past(load_en, 2)) |-> $stable(spi_miso));

    // R1: no strobe in the first cycle out of reset
    a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rx_valid);
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .load_en(load_en),
    .spi_miso(spi_miso), .rx_word(rx_word), .rx_valid(rx_valid),
    .state(fsm_state)
);

// File: tb/spi_chain_slave_tb.sv
`timescale 1ns/1ps
module spi_chain_slave_tb_top;
    localparam int W = 8;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0;
    logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic spi_miso;
    logic load_en = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] rx_word;
    logic rx_valid;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [W-1:0] echo;
    logic [63:0] got;

    always #2 clk = ~clk;

    spi_chain_slave #(.WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso), .load_en(load_en), .load_data(load_data),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always @(negedge clk) if (rx_valid) vcount++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input int m);
        cpol = m[1];
        cpha = m[0];
        spi_sclk = m[1];
        wait_clk(H);
    endtask

    task automatic run_frame(input int nbits, input logic [63:0] data,
                             input bit mid_load, output logic [63:0] rx);
        rx = '0;
        vcount = 0;
        spi_cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                spi_mosi = data[nbits-1-i];
                wait_clk(H);
                rx = {rx[62:0], spi_miso};
                spi_sclk = ~cpol;
                wait_clk(H);
                spi_sclk = cpol;
            end else begin
                spi_sclk = ~cpol;
                spi_mosi = data[nbits-1-i];
                wait_clk(H);
                rx = {rx[62:0], spi_miso};
                spi_sclk = cpol;
                wait_clk(H);
            end
            if (mid_load && i == 3) begin
                load_data = 8'hFF;
                load_en = 1'b1;
                wait_clk(1);
                load_en = 1'b0;
            end
        end
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R1: reset state
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 rx_word", rx_word, 0);
        chk("R1 miso", spi_miso, 0);
        echo = '0;

        // R2 R4 R5 R6: every byte once, 64 per mode
        for (int m = 0; m < 4; m++) begin
            set_mode(m);
            for (int k = 0; k < 64; k++) begin
                logic [W-1:0] v;
                v = W'(k * 4 + m);
                run_frame(W, 64'(v), 1'b0, got);
                chk(cpha ? "R6 R4 echo out" : "R5 R4 echo out", got[W-1:0], 64'(echo));
                chk("R2 rx_word", rx_word, 64'(v));
                chk("R3 one strobe", vcount, 1);
                echo = v;
            end
        end

        // R7: long frames act as an 8-bit delay stage
        for (int m = 0; m < 4; m += 3) begin
            logic [23:0] d;
            set_mode(m);
            d = (m == 0) ? 24'h5A_C3_17 : 24'hE4_0F_99;
            run_frame(24, 64'(d), 1'b0, got);
            chk("R7 chain out", got[23:0], 64'({echo, d[23:8]}));
            chk("R7 rx_word", rx_word, 64'(d[7:0]));
            chk("R7 one strobe", vcount, 1);
            echo = d[7:0];
        end

        // R8: idle load replaces the echo
        set_mode(1);
        load_data = 8'hA5;
        load_en = 1'b1;
        wait_clk(1);
        load_en = 1'b0;
        wait_clk(4);
        run_frame(W, 64'h3C, 1'b0, got);
        chk("R8 loaded word out", got[W-1:0], 64'hA5);
        chk("R8 rx_word", rx_word, 64'h3C);
        echo = 8'h3C;

        // R9: load during a frame is ignored
        set_mode(2);
        run_frame(W, 64'h81, 1'b1, got);
        chk("R9 echo before", got[W-1:0], 64'(echo));
        echo = 8'h81;
        run_frame(W, 64'h42, 1'b0, got);
        chk("R9 echo after mid-frame load", got[W-1:0], 64'h81);
        echo = 8'h42;

        // R10: bus activity while deselected
        vcount = 0;
        for (int t = 0; t < 10; t++) begin
            spi_sclk = ~spi_sclk;
            spi_mosi = t[0];
            wait_clk(H);
        end
        spi_sclk = cpol;
        wait_clk(H);
        chk("R10 no strobe", vcount, 0);
        chk("R10 rx_word held", rx_word, 64'h42);
        run_frame(W, 64'h00, 1'b0, got);
        chk("R10 echo unchanged", got[W-1:0], 64'h42);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule